// File: doc/BRIEF.md
# Prioritized Serial-Port Interrupt Identifier

This block sits beside a serial-port core and turns four raw condition flags into one host interrupt line and an identification byte. The four causes are a receiver line error, received data ready, transmit holding register empty and a modem-line change. Each cause is recorded on the rising edge of its flag and held until the host action that services it.

A per-cause enable mask decides which recorded causes may be reported. An extra gate input, driven from an auxiliary output bit of the modem control logic, masks only the final interrupt line. When several enabled causes are held, only the most urgent one is shown in the identification byte. Servicing that cause reveals the next one down. Detecting the conditions is done elsewhere.

Top module: `serial_irq_prioritizer`

## Requirements
- R1: While reset is asserted and directly after it, no cause is held, `irq` is 0 and `iid` reads 8'h01.
- R2: A cause is recorded at the clock edge where its `src_flag` bit is sampled high after having been low on the previous edge. A flag held high records nothing further.
- R3: The enable bits are `src_en[0]` data ready, `src_en[1]` transmit empty, `src_en[2]` line error and `src_en[3]` modem change. The `src_flag` bits use the same order. A recorded cause whose enable is 0 is kept but not reported, and it is reported as soon as its enable is set.
- R4: `iid[0]` is 0 when an enabled cause is held and 1 otherwise. `iid[7:4]` is always 0.
- R5: `iid[3:1]` names the highest-priority enabled held cause, in this order: line error 3'b011, data ready 3'b010, transmit empty 3'b001, modem change 3'b000.
- R6: `irq` is 1 exactly when an enabled cause is held and `irq_gate` is 1. With `irq_gate` at 0, `irq` stays 0 and `iid` is unaffected.
- R7: A `lsr_rd` pulse clears the line-error cause.
- R8: A `rbr_rd` pulse clears the data-ready cause, and a `msr_rd` pulse clears the modem-change cause.
- R9: The transmit-empty cause clears on a `thr_wr` pulse, or on an `iid_rd` pulse in a cycle where `iid[3:1]` reports 3'b001 with `iid[0]` at 0. An `iid_rd` in any other cycle leaves it held.
- R10: If a new rising edge of a flag coincides with the clear pulse for that cause, the cause stays held.
- R11: After the reported cause is cleared, the next enabled held cause in priority order is reported from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag | input | 4 | Raw condition flags (bit order as in R3) |
| src_en | input | 4 | Per-cause enable mask |
| irq_gate | input | 1 | Auxiliary output bit that masks the interrupt line |
| rbr_rd | input | 1 | Pulse: receive data read |
| thr_wr | input | 1 | Pulse: transmit holding register written |
| iid_rd | input | 1 | Pulse: identification byte read |
| lsr_rd | input | 1 | Pulse: line status read |
| msr_rd | input | 1 | Pulse: modem status read |
| irq | output | 1 | Host interrupt line |
| iid | output | 8 | Identification byte |

## Verification
All four flags are raised one after another with everything enabled. The causes are then serviced from the top down, which shows whether the priority order and the step-down reporting are right. Other patterns hold back one cause with the enable mask or the gate input, to separate a held cause from a reported one. The transmit-empty cause is read through the identification byte both while it is shown and while a higher cause hides it, which tells the conditional clear apart from an unconditional one. Last, a flag edge is made to coincide with its clear, and a flag is then left high, to separate a new edge from a held level.

// File: rtl/serial_irq_prioritizer.sv
module serial_irq_prioritizer #(
  parameter int SRC_N = 4,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_flag,
  input  logic [SRC_N-1:0] src_en,
  input  logic             irq_gate,
  input  logic             rbr_rd,
  input  logic             thr_wr,
  input  logic             iid_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  output logic             irq,
  output logic [ID_W-1:0]  iid
);
  localparam int RDA = 0;
  localparam int TXE = 1;
  localparam int LER = 2;
  localparam int MDM = 3;
  localparam int CODE_W = 3;

  logic [SRC_N-1:0] flag_q, pend_q, rise, live, clr;
  logic [CODE_W-1:0] code;
  logic              any;

  assign rise = src_flag & ~flag_q;
  assign live = pend_q & src_en;
  assign any  = |live;

  always_comb begin
    if (live[LER])      code = 3'b011;
    else if (live[RDA]) code = 3'b010;
    else if (live[TXE]) code = 3'b001;
    else                code = 3'b000;
  end

  always_comb begin
    clr      = '0;
    clr[RDA] = rbr_rd;
    clr[TXE] = thr_wr | (iid_rd & any & (code == 3'b001));
    clr[LER] = lsr_rd;
    clr[MDM] = msr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      pend_q <= '0;
    end else begin
      flag_q <= src_flag;
      pend_q <= (pend_q & ~clr) | rise;
    end
  end

  assign irq = any & irq_gate;
  assign iid = {{(ID_W-CODE_W-1){1'b0}}, code, ~any};

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (iid == 8'h01 && !irq));

  p_edge_records_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise[LER] |=> pend_q[LER]);

  p_disabled_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == '0) |-> (iid == 8'h01 && !irq));

  p_irq_means_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!iid[0] && iid[7:4] == 4'h0));

  p_line_err_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[LER] && src_en[LER]) |-> (iid[3:0] == 4'b0110));

  p_gate_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_gate |-> !irq);

  p_lsr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rise[LER]) |=> !pend_q[LER]);

  p_msr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !rise[MDM]) |=> !pend_q[MDM]);

  p_iid_rd_keeps_txe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && iid[3:0] != 4'b0010 && !thr_wr && !rise[TXE])
      |=> (pend_q[TXE] == $past(pend_q[TXE])));

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[RDA] && rbr_rd) |=> pend_q[RDA]);
endmodule

// File: tb/sim_serial_irq_prioritizer.sv
module sim_serial_irq_prioritizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] src_flag = '0, src_en = '0;
  logic irq_gate = 1'b0;
  logic rbr_rd = 0, thr_wr = 0, iid_rd = 0, lsr_rd = 0, msr_rd = 0;
  logic irq;
  logic [7:0] iid;

  int total = 0, fails = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  serial_irq_prioritizer u0 (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .irq_gate(irq_gate), .rbr_rd(rbr_rd), .thr_wr(thr_wr), .iid_rd(iid_rd),
    .lsr_rd(lsr_rd), .msr_rd(msr_rd), .irq(irq), .iid(iid)
  );

  // pulses: [0] rbr_rd [1] thr_wr [2] iid_rd [3] lsr_rd [4] msr_rd
  task automatic step(input logic [3:0] flags, input logic [3:0] en,
                      input logic gate, input logic [4:0] pul,
                      input logic exp_irq, input logic [7:0] exp_iid,
                      input string tag);
    @(negedge clk);
    src_flag = flags; src_en = en; irq_gate = gate;
    {msr_rd, lsr_rd, iid_rd, thr_wr, rbr_rd} = pul;
    @(posedge clk);
    #1;
    {msr_rd, lsr_rd, iid_rd, thr_wr, rbr_rd} = '0;
    exp_q.push_back({exp_irq, exp_iid});
    tag_q.push_back(tag);
  endtask

  always begin
    @(posedge clk);
    #8;
    while (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({irq, iid} !== e) begin
        fails++;
        $display("FAIL %s: irq/iid got %0b/%02h expected %0b/%02h",
                 t, irq, iid, e[8], e[7:0]);
      end
    end
  end

  initial begin
    step(4'h0, 4'h0, 1'b0, 5'b00000, 1'b0, 8'h01, "R1 in reset");
    rst_n = 1'b1;
    step(4'b0000, 4'hF, 1'b1, 5'b00000, 1'b0, 8'h01, "R1 after reset");
    step(4'b1000, 4'hF, 1'b1, 5'b00000, 1'b1, 8'h00, "R2 modem edge");
    step(4'b1010, 4'hF, 1'b1, 5'b00000, 1'b1, 8'h02, "R5 txe over modem");
    step(4'b1011, 4'hF, 1'b1, 5'b00000, 1'b1, 8'h04, "R5 data over txe");
    step(4'b1111, 4'hF, 1'b1, 5'b00000, 1'b1, 8'h06, "R5 line error top");
    step(4'b1111, 4'hF, 1'b1, 5'b01000, 1'b1, 8'h04, "R7 R11 lsr read");
    step(4'b1111, 4'hF, 1'b1, 5'b00001, 1'b1, 8'h02, "R8 R11 rbr read");
    step(4'b1111, 4'hF, 1'b1, 5'b00100, 1'b1, 8'h00, "R9 iid read clears txe");
    step(4'b1111, 4'hF, 1'b1, 5'b10000, 1'b0, 8'h01, "R8 R4 msr read");
    step(4'b0000, 4'hF, 1'b1, 5'b00000, 1'b0, 8'h01, "R2 falling edges");
    step(4'b0100, 4'hF, 1'b0, 5'b00000, 1'b0, 8'h06, "R6 gate low");
    step(4'b0100, 4'hF, 1'b1, 5'b00000, 1'b1, 8'h06, "R6 gate high");
    step(4'b0100, 4'hF, 1'b1, 5'b01000, 1'b0, 8'h01, "R7 clear");
    step(4'b0000, 4'h0, 1'b1, 5'b00000, 1'b0, 8'h01, "R3 all disabled");
    step(4'b0001, 4'h0, 1'b1, 5'b00000, 1'b0, 8'h01, "R3 held hidden");
    step(4'b0001, 4'h1, 1'b1, 5'b00000, 1'b1, 8'h04, "R3 enable reveals");
    step(4'b0001, 4'h1, 1'b1, 5'b00001, 1'b0, 8'h01, "R8 rbr clear");
    step(4'b0000, 4'h8, 1'b1, 5'b00000, 1'b0, 8'h01, "R3 only modem on");
    step(4'b1100, 4'h8, 1'b1, 5'b00000, 1'b1, 8'h00, "R3 line error masked");
    step(4'b1100, 4'h8, 1'b1, 5'b10000, 1'b0, 8'h01, "R8 msr clear");
    step(4'b1100, 4'h4, 1'b1, 5'b00000, 1'b1, 8'h06, "R3 held line error");
    step(4'b1100, 4'h4, 1'b1, 5'b01000, 1'b0, 8'h01, "R7 clear held");
    step(4'b0010, 4'hF, 1'b1, 5'b00000, 1'b1, 8'h02, "R2 txe edge");
    step(4'b0010, 4'hF, 1'b1, 5'b00010, 1'b0, 8'h01, "R9 thr write clears");
    step(4'b0000, 4'hF, 1'b1, 5'b00000, 1'b0, 8'h01, "R4 idle");
    step(4'b0011, 4'hF, 1'b1, 5'b00000, 1'b1, 8'h04, "R5 data over txe");
    step(4'b0011, 4'hF, 1'b1, 5'b00100, 1'b1, 8'h04, "R9 hidden txe kept");
    step(4'b0011, 4'hF, 1'b1, 5'b00001, 1'b1, 8'h02, "R11 txe next");
    step(4'b0011, 4'hF, 1'b1, 5'b00010, 1'b0, 8'h01, "R9 thr write");
    step(4'b0111, 4'hF, 1'b1, 5'b01000, 1'b1, 8'h06, "R10 edge beats clear");
    step(4'b0111, 4'hF, 1'b1, 5'b01000, 1'b0, 8'h01, "R2 level no refire");
    step(4'b0111, 4'hF, 1'b1, 5'b00000, 1'b0, 8'h01, "R2 still quiet");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule